// File: doc/BRIEF.md
# ECC Error Log Capture Register

This block records error events reported by an in-band ECC checker sitting beside a memory controller. Each event carries a kind (correctable or uncorrectable), the byte address of the failing access and a 16-bit syndrome. The events land in a 64-bit log word. The log holds a 32-byte-aligned address field, the syndrome and two sticky kind flags.

A 16-bit status register keeps its own sticky copy of the two error kinds. A 16-bit command register selects which kinds raise the level interrupt. Software reads the three registers on plain read ports and writes them through single-cycle write strobes. Writing ones to the log flags and to the status bits clears them. Until software clears them, the first captured address and syndrome are preserved, and the interrupt stays raised.

The event input is a valid/ready stream. `ev_ready` is held high at all times, because the block never applies back-pressure. An event is taken in every cycle where `ev_valid` is high. A producer may therefore hold `ev_valid` for exactly one cycle per event and need not wait.

Top module: `ecc_err_log`

## Requirements
- R1: After reset, `log_q`, `sts_q` and `cmd_q` read zero and `irq` is low.
- R2: An event taken while log bits 63 and 62 are both zero captures `ev_addr[38:5]` into log bits 38:5 and `ev_syn` into log bits 61:46, one cycle later. It also sets log bit 62 when `ev_uncorr`=0 (correctable) or log bit 63 when `ev_uncorr`=1 (uncorrectable).
- R3: An event taken while log bit 62 or 63 is set leaves log bits 61:46 and 38:5 unchanged, but still sets its own kind flag.
- R4: A log write clears log bit 62 or 63 wherever `log_wdata` has a one in that position. A write changes no other log bit, and address and syndrome survive the clear.
- R5: A correctable event sets status bit 6 and an uncorrectable event sets status bit 7. A status write clears each of those two bits where `sts_wdata` has a one in that position.
- R6: A command write loads bits 7:6 from `cmd_wdata`. Bit 6 enables correctable reporting and bit 7 enables uncorrectable reporting. All other command bits read zero, and the command register has no effect on log or status capture.
- R7: `irq` is high exactly while (status bit 6 and command bit 6) or (status bit 7 and command bit 7).
- R8: When an event and a clearing write of its own kind flag arrive in the same cycle, the flag ends up set, in both the log and the status register.
- R9: Log bits 45:39 and 4:0 and status bits 15:8 and 5:0 always read zero. `ev_addr[4:0]` is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | Error event present |
| ev_ready | output | 1 | Always high; events are never stalled |
| ev_uncorr | input | 1 | Event kind: 1 uncorrectable, 0 correctable |
| ev_addr | input | PA_W (39) | Byte address of the failing access |
| ev_syn | input | SYN_W (16) | ECC syndrome of the event |
| log_wr | input | 1 | Log write strobe (write-one-to-clear on bits 63:62) |
| log_wdata | input | 64 | Log write data |
| log_q | output | 64 | Log word |
| sts_wr | input | 1 | Status write strobe (write-one-to-clear on bits 7:6) |
| sts_wdata | input | 16 | Status write data |
| sts_q | output | 16 | Status register |
| cmd_wr | input | 1 | Command write strobe |
| cmd_wdata | input | 16 | Command write data |
| cmd_q | output | 16 | Command register |
| irq | output | 1 | Level interrupt request |

## Verification
The bench builds the block with its default parameters: a 39-bit address and a 16-bit syndrome, which matches the fixed log layout. At this size every combination of prior log flag state (four), incoming event kind (none, correctable, uncorrectable) and clear mask (four) can be swept. This covers the hold and collision rules of R3 and R8 in every ordering. All-ones addresses and syndromes expose any leakage into the reserved fields. A second sweep walks all sixteen pairings of status state and command enables to cover the interrupt equation.

// File: rtl/ecclog_pkg.sv
package ecclog_pkg;

  localparam int LOG_W       = 64;
  localparam int REG_W       = 16;
  localparam int ADDR_LSB    = 5;
  localparam int SYN_LSB     = 46;
  localparam int LOG_CE_BIT  = 62;
  localparam int LOG_UE_BIT  = 63;
  localparam int STS_CE_BIT  = 6;
  localparam int STS_UE_BIT  = 7;
  localparam int KINDS       = 2;

  typedef enum logic {
    KIND_CORR   = 1'b0,
    KIND_UNCORR = 1'b1
  } err_kind_e;

  // index 0 = correctable, index 1 = uncorrectable
  typedef logic [KINDS-1:0] kind_vec_t;

endpackage

// File: rtl/ecclog_evt_decode.sv
module ecclog_evt_decode
  import ecclog_pkg::*;
(
  input  logic      fire,
  input  logic      uncorr,
  output kind_vec_t set_vec
);
  err_kind_e kind;

  always_comb begin
    kind    = err_kind_e'(uncorr);
    set_vec = '0;
    if (fire) begin
      set_vec[0] = (kind == KIND_CORR);
      set_vec[1] = (kind == KIND_UNCORR);
    end
  end
endmodule

// File: rtl/ecclog_w1c_bits.sv
module ecclog_w1c_bits #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)      q[i] <= 1'b0;
      else if (set[i]) q[i] <= 1'b1;   // a new event beats a clear
      else if (clr[i]) q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/ecclog_log_reg.sv
module ecclog_log_reg
  import ecclog_pkg::*;
#(
  parameter int PA_W  = 39,
  parameter int SYN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  kind_vec_t        set_vec,
  input  logic [PA_W-1:0]  ev_addr,
  input  logic [SYN_W-1:0] ev_syn,
  input  kind_vec_t        clr_vec,
  output logic [LOG_W-1:0] log_word
);
  localparam int AF_W = PA_W - ADDR_LSB;

  kind_vec_t        flags;
  logic [AF_W-1:0]  addr_q;
  logic [SYN_W-1:0] syn_q;
  logic             capture;

  ecclog_w1c_bits #(.N(KINDS)) u_flags (
    .clk  (clk),
    .rst_n(rst_n),
    .set  (set_vec),
    .clr  (clr_vec),
    .q    (flags)
  );

  // Capture only into an empty log; the first error's details are kept.
  assign capture = fire && (flags == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      syn_q  <= '0;
    end else if (capture) begin
      addr_q <= ev_addr[PA_W-1:ADDR_LSB];
      syn_q  <= ev_syn;
    end
  end

  always_comb begin
    log_word                     = '0;
    log_word[ADDR_LSB +: AF_W]   = addr_q;
    log_word[SYN_LSB +: SYN_W]   = syn_q;
    log_word[LOG_CE_BIT]         = flags[0];
    log_word[LOG_UE_BIT]         = flags[1];
  end
endmodule

// File: rtl/ecclog_ctrl_regs.sv
module ecclog_ctrl_regs
  import ecclog_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  kind_vec_t        set_vec,
  input  logic             sts_wr,
  input  logic [REG_W-1:0] sts_wdata,
  input  logic             cmd_wr,
  input  logic [REG_W-1:0] cmd_wdata,
  output logic [REG_W-1:0] sts_word,
  output logic [REG_W-1:0] cmd_word,
  output logic             irq
);
  kind_vec_t sts_bits;
  kind_vec_t sts_clr;
  kind_vec_t en_bits;

  assign sts_clr = sts_wr ? {sts_wdata[STS_UE_BIT], sts_wdata[STS_CE_BIT]} : '0;

  ecclog_w1c_bits #(.N(KINDS)) u_sts (
    .clk  (clk),
    .rst_n(rst_n),
    .set  (set_vec),
    .clr  (sts_clr),
    .q    (sts_bits)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)      en_bits <= '0;
    else if (cmd_wr) en_bits <= {cmd_wdata[STS_UE_BIT], cmd_wdata[STS_CE_BIT]};
  end

  always_comb begin
    sts_word             = '0;
    sts_word[STS_CE_BIT] = sts_bits[0];
    sts_word[STS_UE_BIT] = sts_bits[1];
    cmd_word             = '0;
    cmd_word[STS_CE_BIT] = en_bits[0];
    cmd_word[STS_UE_BIT] = en_bits[1];
  end

  assign irq = |(sts_bits & en_bits);
endmodule

// File: rtl/ecc_err_log.sv
module ecc_err_log
  import ecclog_pkg::*;
#(
  parameter int PA_W  = 39,
  parameter int SYN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_valid,
  output logic             ev_ready,
  input  logic             ev_uncorr,
  input  logic [PA_W-1:0]  ev_addr,
  input  logic [SYN_W-1:0] ev_syn,
  input  logic             log_wr,
  input  logic [LOG_W-1:0] log_wdata,
  output logic [LOG_W-1:0] log_q,
  input  logic             sts_wr,
  input  logic [REG_W-1:0] sts_wdata,
  output logic [REG_W-1:0] sts_q,
  input  logic             cmd_wr,
  input  logic [REG_W-1:0] cmd_wdata,
  output logic [REG_W-1:0] cmd_q,
  output logic             irq
);
  kind_vec_t set_vec;
  kind_vec_t log_clr;
  logic      fire;

  assign ev_ready = 1'b1;
  assign fire     = ev_valid && ev_ready;
  assign log_clr  = log_wr ? {log_wdata[LOG_UE_BIT], log_wdata[LOG_CE_BIT]} : '0;

  ecclog_evt_decode u_dec (
    .fire   (fire),
    .uncorr (ev_uncorr),
    .set_vec(set_vec)
  );

  ecclog_log_reg #(.PA_W(PA_W), .SYN_W(SYN_W)) u_log (
    .clk     (clk),
    .rst_n   (rst_n),
    .fire    (fire),
    .set_vec (set_vec),
    .ev_addr (ev_addr),
    .ev_syn  (ev_syn),
    .clr_vec (log_clr),
    .log_word(log_q)
  );

  ecclog_ctrl_regs u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_vec  (set_vec),
    .sts_wr   (sts_wr),
    .sts_wdata(sts_wdata),
    .cmd_wr   (cmd_wr),
    .cmd_wdata(cmd_wdata),
    .sts_word (sts_q),
    .cmd_word (cmd_q),
    .irq      (irq)
  );
endmodule

// File: rtl/ecc_err_log_chk.sv
module ecc_err_log_chk #(
  parameter int PA_W  = 39,
  parameter int SYN_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ev_valid,
  input logic             ev_uncorr,
  input logic             log_wr,
  input logic [63:0]      log_wdata,
  input logic [63:0]      log_q,
  input logic             sts_wr,
  input logic [15:0]      sts_wdata,
  input logic [15:0]      sts_q,
  input logic             cmd_wr,
  input logic [15:0]      cmd_wdata,
  input logic [15:0]      cmd_q,
  input logic             irq
);
  p_ce_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && !ev_uncorr) |=> log_q[62]);

  p_hold_fields_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (log_q[63] || log_q[62]) |=> ($stable(log_q[38:5]) && $stable(log_q[61:46])));

  p_w1c_log_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (log_wr && log_wdata[62] && !(ev_valid && !ev_uncorr)) |=> !log_q[62]);

  p_ue_status_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_uncorr) |=> sts_q[7]);

  p_cmd_no_effect_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !ev_valid && !log_wr) |=> $stable(log_q));

  p_irq_raise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_uncorr && cmd_q[7] && !(cmd_wr && !cmd_wdata[7])) |=> irq);

  p_event_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_uncorr && log_wr && log_wdata[63] && sts_wr && sts_wdata[7])
      |=> (log_q[63] && sts_q[7]));

  p_reserved_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (log_q[45:39] == '0) && (log_q[4:0] == '0) && (sts_q[15:8] == '0) && (sts_q[5:0] == '0));
endmodule

bind ecc_err_log ecc_err_log_chk #(.PA_W(PA_W), .SYN_W(SYN_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ev_valid (ev_valid),
  .ev_uncorr(ev_uncorr),
  .log_wr   (log_wr),
  .log_wdata(log_wdata),
  .log_q    (log_q),
  .sts_wr   (sts_wr),
  .sts_wdata(sts_wdata),
  .sts_q    (sts_q),
  .cmd_wr   (cmd_wr),
  .cmd_wdata(cmd_wdata),
  .cmd_q    (cmd_q),
  .irq      (irq)
);

// File: tb/ecc_err_log_tb.sv
module ecc_err_log_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ev_valid = 1'b0, ev_uncorr = 1'b0;
  logic        ev_ready;
  logic [38:0] ev_addr = '0;
  logic [15:0] ev_syn = '0;
  logic        log_wr = 1'b0, sts_wr = 1'b0, cmd_wr = 1'b0;
  logic [63:0] log_wdata = '0;
  logic [15:0] sts_wdata = '0, cmd_wdata = '0;
  logic [63:0] log_q;
  logic [15:0] sts_q, cmd_q;
  logic        irq;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  // bench model state
  logic [1:0]  m_lf = '0, m_st = '0, m_cmd = '0;  // [0]=correctable [1]=uncorrectable
  logic [33:0] m_a = '0;
  logic [15:0] m_s = '0;

  always #5 clk = ~clk;

  ecc_err_log u_dut (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ready(ev_ready),
    .ev_uncorr(ev_uncorr), .ev_addr(ev_addr), .ev_syn(ev_syn),
    .log_wr(log_wr), .log_wdata(log_wdata), .log_q(log_q),
    .sts_wr(sts_wr), .sts_wdata(sts_wdata), .sts_q(sts_q),
    .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata), .cmd_q(cmd_q), .irq(irq)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_log();
    return {m_lf[1], m_lf[0], m_s, 7'b0, m_a, 5'b0};
  endfunction

  // Called at a negedge; applies one cycle of stimulus and returns at the next negedge.
  task automatic step(input logic v, input logic ue, input logic [38:0] a, input logic [15:0] s,
                      input logic lw, input logic [63:0] lwd,
                      input logic sw, input logic [15:0] swd,
                      input logic cw, input logic [15:0] cwd);
    logic [1:0] setv, lclr, sclr;
    ev_valid = v; ev_uncorr = ue; ev_addr = a; ev_syn = s;
    log_wr = lw; log_wdata = lwd; sts_wr = sw; sts_wdata = swd;
    cmd_wr = cw; cmd_wdata = cwd;
    @(posedge clk);
    #1;
    setv = v ? (ue ? 2'b10 : 2'b01) : 2'b00;
    lclr = lw ? {lwd[63], lwd[62]} : 2'b00;
    sclr = sw ? {swd[7], swd[6]} : 2'b00;
    if (v && m_lf == 2'b00) begin
      m_a = a[38:5];
      m_s = s;
    end
    m_lf = (m_lf & ~lclr) | setv;
    m_st = (m_st & ~sclr) | setv;
    if (cw) m_cmd = {cwd[7], cwd[6]};
    @(negedge clk);
    ev_valid = 1'b0; log_wr = 1'b0; sts_wr = 1'b0; cmd_wr = 1'b0;
  endtask

  task automatic idle();
    step(0, 0, '0, '0, 0, '0, 0, '0, 0, '0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 log", log_q, 64'h0);
    chk("R1 sts", {48'h0, sts_q}, 64'h0);
    chk("R1 cmd", {48'h0, cmd_q}, 64'h0);
    chk("R1 irq", {63'h0, irq}, 64'h0);
    rst_n = 1'b1;
    idle();
    chk("R1 ready", {63'h0, ev_ready}, 64'h1);

    // Sweep: prior flags f, event kind e (0 none,1 corr,2 uncorr), clear mask c
    for (int f = 0; f < 4; f++) begin
      for (int e = 0; e < 3; e++) begin
        for (int c = 0; c < 4; c++) begin
          logic [38:0] a0;
          logic [15:0] s0;
          string tag;
          // clear everything; all-ones log write also hits non-flag bits (R4)
          step(0, 0, '0, '0, 1, 64'hFFFF_FFFF_FFFF_FFFF, 1, 16'hFFFF, 0, '0);
          chk("R4 cleared", {62'h0, log_q[63:62]}, 64'h0);
          chk("R4 fields kept", log_q, exp_log());
          // build prior state
          a0 = 39'h7F_FFFF_FFFF ^ (39'(f) << 20) ^ (39'(e) << 9) ^ 39'(c);
          s0 = 16'hFFFF ^ 16'(f * 16 + e * 4 + c);
          if (f[0]) step(1, 0, a0, s0, 0, '0, 0, '0, 0, '0);
          if (f[1]) step(1, 1, ~a0, ~s0, 0, '0, 0, '0, 0, '0);
          // stimulus cycle
          step(e != 0, e == 2, a0 ^ 39'h55_5555_5555, s0 ^ 16'hA5A5,
               1, {c[1], c[0], 62'h3FFF_FFFF_FFFF_FFFF}, 1, {8'hFF, c[1], c[0], 6'h3F}, 0, '0);
          if (e != 0 && c[e-1]) tag = "R8";
          else if (e != 0 && f != 0) tag = "R3";
          else if (e != 0) tag = "R2";
          else tag = "R4";
          chk(tag, log_q, exp_log());
          chk("R5", {48'h0, sts_q}, {48'h0, 8'h0, m_st, 6'h0});
          chk("R9", {57'h0, log_q[45:39], log_q[4:0], sts_q[15:8], sts_q[5:0]}, 64'h0);
        end
      end
    end

    // Interrupt sweep: status state x command enables
    for (int s = 0; s < 4; s++) begin
      for (int c = 0; c < 4; c++) begin
        step(0, 0, '0, '0, 1, 64'hC000_0000_0000_0000, 1, 16'h00C0,
             1, {8'hFF, c[1], c[0], 6'h3F});
        chk("R6 cmd", {48'h0, cmd_q}, {48'h0, 8'h0, m_cmd, 6'h0});
        if (s[0]) step(1, 0, 39'h12_3456_78E0, 16'h0F0F, 0, '0, 0, '0, 0, '0);
        if (s[1]) step(1, 1, 39'h01_2345_6780, 16'hF0F0, 0, '0, 0, '0, 0, '0);
        chk("R6 log unaffected", log_q, exp_log());
        chk("R7 irq", {63'h0, irq}, {63'h0, |(m_st & m_cmd)});
        // clearing status drops the request
        step(0, 0, '0, '0, 0, '0, 1, 16'h00C0, 0, '0);
        chk("R7 irq after clear", {63'h0, irq}, 64'h0);
      end
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule